// File: doc/BRIEF.md
# Fifteen-Source Interrupt Level Controller

The block gathers fifteen external interrupt request lines, numbered 1 to 15. Each line passes through a two-flop synchronizer and then a detector. The detector is set by software to one of four trigger modes: high level, low level, rising edge or falling edge. A detected request sets a per-source pending latch. The enabled pending requests are reduced to the number of the highest one, and that number drives a 4-bit interrupt level to the processor.

The level is held in a register. Once it is nonzero it stays fixed until software issues an explicit re-arbitrate command. The command clears the level for one cycle, and on the following cycle the controller loads the winner among the requests still pending. While the level is zero, the controller loads a new winner as soon as one appears. Source 15 serves as the non-maskable source and cannot be disabled.

Software reaches six word-indexed registers over a simple synchronous write and combinational read bus. Two of them hold the trigger modes. The others give the pending sense, the write-one-to-clear request clear, the disable mask, and the level together with the re-arbitrate command. The arbiter runs a three-state machine: `ARB_IDLE` (level zero, watching for requests), `ARB_HOLD` (level latched) and `ARB_REARB` (the cycle after a command). Its transitions are: `ARB_IDLE`→`ARB_HOLD` when an enabled request exists; `ARB_REARB`→`ARB_HOLD` or `ARB_REARB`→`ARB_IDLE` depending on whether one exists; any state→`ARB_REARB` on the command. Each source runs a two-state machine, `SRC_CLEAR`→`SRC_PENDING` on detection and `SRC_PENDING`→`SRC_CLEAR` on a clear while not detecting.

Top module: `irq_level_ctrl`

## Requirements
- R1: After reset the level is 0, both trigger registers read 0, the sense register reads 0 and the mask register reads 0x7FFE (every maskable source disabled).
- R2: Word index 0 holds the 2-bit trigger fields of sources 15 to 8 and index 1 those of sources 7 to 1, with each field at bits 2*(n mod 8)+1:2*(n mod 8). Bits 1:0 of index 1 are reserved and read as zero.
- R3: Trigger code 0 (high level) and code 1 (low level) keep the pending bit set while the synchronized input is asserted, and the bit stays set after the input is deasserted.
- R4: Trigger code 2 (rising edge) and code 3 (falling edge) set the pending bit on the chosen edge of the synchronized input; an input pulse held for two clocks is caught, and the idle input value sets nothing.
- R5: Word index 2 reports the pending bit of source n in bit n, whatever the mask says; writes to it are ignored and bit 0 reads as zero.
- R6: Writing 1 to bit n of word index 3 clears source n's pending bit on that clock; 0 bits have no effect; the register reads as zero; a clear has no effect while a level-mode source is still asserted.
- R7: In word index 4, bit n set disables source n from arbitration; bits 0 and 15 read as zero, and source 15 always takes part.
- R8: The level equals the highest-numbered enabled pending source, or 0 when there is none; while the level is 0 it loads a new winner on the clock after its pending bit sets.
- R9: A nonzero level does not change without a re-arbitrate command, even when a higher source becomes pending or its own request is cleared.
- R10: Word index 5 reads the level in bits 3:0. A write to it with bit 4 set makes the level 0 on that clock, and the level then takes the re-arbitrated value one clock later. A write with bit 4 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 15 | Raw request lines, bit n is source n (bits 15:1) |
| bus_wr | input | 1 | Register write strobe, sampled at the clock edge |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational from bus_addr |
| irq_level | output | 4 | Latched interrupt level, 0 for none |

## Verification
Every source is tried under all four trigger codes, first with its idle input value and then with an active pattern. The patterns are a held level followed by release, and a two-clock pulse toward the chosen edge. Together they separate field placement in the two trigger registers, polarity, and level versus edge behaviour. Mixed patterns with several sources asserted at once distinguish priority order from latching: a higher source rises while the level is held, a request is cleared under a held level, and commands are issued with and without the re-arbitrate bit. Masked-versus-unmasked patterns, including the non-maskable source, separate the raw sense view from the arbitrated level. The clock on which the level changes is compared exactly after a command and after a first request.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        TRIG_HIGH = 2'd0,
        TRIG_LOW  = 2'd1,
        TRIG_RISE = 2'd2,
        TRIG_FALL = 2'd3
    } trig_mode_e;

    typedef enum logic [2:0] {
        RA_TRIG_HI = 3'd0,
        RA_TRIG_LO = 3'd1,
        RA_SENSE   = 3'd2,
        RA_CLEAR   = 3'd3,
        RA_MASK    = 3'd4,
        RA_LEVEL   = 3'd5
    } reg_idx_e;

    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_HOLD  = 2'd1,
        ARB_REARB = 2'd2
    } arb_state_e;

    typedef enum logic {
        SRC_CLEAR   = 1'b0,
        SRC_PENDING = 1'b1
    } src_state_e;

    localparam int REARB_BIT = 4;

endpackage

// File: rtl/irqc_source.sv
module irqc_source
    import irqc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_raw,
    input  trig_mode_e mode,
    input  logic       clr,
    output logic       pend
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;
    logic                   sig;
    logic                   active;
    src_state_e             st_q;
    src_state_e             st_d;

    assign sig = sync_q[SYNC_STAGES-1];

    // Input synchronizer plus one-cycle history for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], irq_raw};
            last_q <= sig;
        end
    end

    // Trigger detection per mode
    always_comb begin
        active = 1'b0;
        unique case (mode)
            TRIG_HIGH: active = sig;
            TRIG_LOW:  active = ~sig;
            TRIG_RISE: active = sig & ~last_q;
            TRIG_FALL: active = ~sig & last_q;
        endcase
    end

    // Pending state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SRC_CLEAR;
        else        st_q <= st_d;
    end

    // Pending transitions: detection wins over a clear on the same clock
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SRC_CLEAR:   if (active)          st_d = SRC_PENDING;
            SRC_PENDING: if (clr && !active)  st_d = SRC_CLEAR;
        endcase
    end

    assign pend = (st_q == SRC_PENDING);

    AST_DETECT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> pend); // R3

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !clr) |=> (pend == $past(pend))); // R4

    AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !active) |=> !pend); // R6

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int DW   = 16,
    parameter int AW   = 3,
    parameter int NSRC = DW - 1,
    parameter int LW   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [AW-1:0]       bus_addr,
    input  logic [DW-1:0]       bus_wdata,
    input  logic [NSRC:1]       pend,
    input  logic [LW-1:0]       level,
    output logic [2*NSRC+1:2]   src_modes,
    output logic [NSRC:1]       src_enable,
    output logic [NSRC:1]       clr_vec,
    output logic                clr_cmd,
    output logic [DW-1:0]       bus_rdata
);

    localparam logic [DW-1:0] TRG_LO_KEEP = ~(DW'(3));
    localparam logic [DW-1:0] MASK_KEEP   = ~(DW'(1) | (DW'(1) << NSRC));

    logic [DW-1:0] trig_hi_q;
    logic [DW-1:0] trig_lo_q;
    logic [DW-1:0] mask_q;
    reg_idx_e      idx;

    assign idx = reg_idx_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_hi_q <= '0;
            trig_lo_q <= '0;
            mask_q    <= MASK_KEEP;
        end else if (bus_wr) begin
            if (idx == RA_TRIG_HI) trig_hi_q <= bus_wdata;
            if (idx == RA_TRIG_LO) trig_lo_q <= bus_wdata & TRG_LO_KEEP;
            if (idx == RA_MASK)    mask_q    <= bus_wdata & MASK_KEEP;
        end
    end

    assign src_modes  = {trig_hi_q, trig_lo_q[DW-1:2]};
    assign src_enable = ~mask_q[NSRC:1];
    assign clr_vec    = (bus_wr && idx == RA_CLEAR) ? bus_wdata[NSRC:1] : '0;
    assign clr_cmd    = bus_wr && (idx == RA_LEVEL) && bus_wdata[REARB_BIT];

    always_comb begin
        bus_rdata = '0;
        case (idx)
            RA_TRIG_HI: bus_rdata = trig_hi_q;
            RA_TRIG_LO: bus_rdata = trig_lo_q;
            RA_SENSE:   bus_rdata = DW'({pend, 1'b0});
            RA_MASK:    bus_rdata = mask_q;
            RA_LEVEL:   bus_rdata = DW'(level);
            default:    bus_rdata = '0;
        endcase
    end

    AST_NMI_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && idx == RA_MASK |=> src_enable[NSRC]); // R7

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
#(
    parameter int NSRC = 15,
    parameter int LW   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC:1]   req,
    input  logic            clr_cmd,
    output logic [LW-1:0]   level
);

    arb_state_e    state_q;
    arb_state_e    state_d;
    logic [LW-1:0] top;
    logic [LW-1:0] level_q;

    function automatic logic [LW-1:0] pick_top(input logic [NSRC:1] r);
        logic [LW-1:0] v;
        v = '0;
        for (int i = 1; i <= NSRC; i++) begin
            if (r[i]) v = LW'(i);
        end
        return v;
    endfunction

    assign top = pick_top(req);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        if (clr_cmd) begin
            state_d = ARB_REARB;
        end else begin
            unique case (state_q)
                ARB_IDLE:  if (top != '0) state_d = ARB_HOLD;
                ARB_HOLD:  state_d = ARB_HOLD;
                ARB_REARB: state_d = (top != '0) ? ARB_HOLD : ARB_IDLE;
                default:   state_d = ARB_IDLE;
            endcase
        end
    end

    // Level output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (clr_cmd) begin
            level_q <= '0;
        end else begin
            unique case (state_q)
                ARB_IDLE:  level_q <= top;
                ARB_REARB: level_q <= top;
                ARB_HOLD:  level_q <= level_q;
                default:   level_q <= '0;
            endcase
        end
    end

    assign level = level_q;

    AST_CMD_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (level == '0)); // R10

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_HOLD && !clr_cmd) |=> $stable(level)); // R9

    AST_IDLE_PICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_IDLE && req != '0 && !clr_cmd) |=> (level != '0)); // R8

    AST_HOLD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_HOLD) |-> (level != '0)); // R8

endmodule

// File: rtl/irq_level_ctrl.sv
module irq_level_ctrl
    import irqc_pkg::*;
#(
    parameter int DW          = 16,
    parameter int AW          = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DW-1:1]     irq_in,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [$clog2(DW)-1:0] irq_level
);

    localparam int NSRC = DW - 1;
    localparam int LW   = $clog2(DW);

    logic [2*NSRC+1:2] src_modes;
    logic [NSRC:1]     src_enable;
    logic [NSRC:1]     clr_vec;
    logic [NSRC:1]     pend;
    logic              clr_cmd;

    irqc_regs #(
        .DW(DW), .AW(AW), .NSRC(NSRC), .LW(LW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .pend       (pend),
        .level      (irq_level),
        .src_modes  (src_modes),
        .src_enable (src_enable),
        .clr_vec    (clr_vec),
        .clr_cmd    (clr_cmd),
        .bus_rdata  (bus_rdata)
    );

    for (genvar n = 1; n <= NSRC; n++) begin : g_src
        irqc_source #(
            .SYNC_STAGES(SYNC_STAGES)
        ) u_src (
            .clk     (clk),
            .rst_n   (rst_n),
            .irq_raw (irq_in[n]),
            .mode    (trig_mode_e'(src_modes[2*n+1 -: 2])),
            .clr     (clr_vec[n]),
            .pend    (pend[n])
        );
    end

    irqc_arbiter #(
        .NSRC(NSRC), .LW(LW)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (pend & src_enable),
        .clr_cmd (clr_cmd),
        .level   (irq_level)
    );

endmodule

// File: tb/irq_level_ctrl_test.sv
module irq_level_ctrl_test;

    localparam int DW = 16;
    localparam int AW = 3;
    localparam int NSRC = DW - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC:1]   irq_in = '0;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [DW-1:0]   bus_wdata = '0;
    logic [DW-1:0]   bus_rdata;
    logic [3:0]      irq_level;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_level_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_in    (irq_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_level (irq_level)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_mode(input int n, input int m);
        logic [15:0] v;
        logic [2:0]  a;
        int          sh;
        a  = (n >= 8) ? 3'd0 : 3'd1;
        sh = 2 * (n % 8);
        rd(a, v);
        v = v & ~(16'd3 << sh);
        v = v | (16'(m) << sh);
        wr(a, v);
    endtask

    task automatic clear_all();
        wr(3'd3, 16'hFFFE);
        wr(3'd5, 16'h0010);
        idle(2);
    endtask

    initial begin
        logic [15:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // Reset state
        check("R1 level", 16'(irq_level), 16'h0000);
        rd(3'd0, v); check("R1 trig_hi", v, 16'h0000);
        rd(3'd1, v); check("R1 trig_lo", v, 16'h0000);
        rd(3'd2, v); check("R1 sense", v, 16'h0000);
        rd(3'd4, v); check("R1 mask", v, 16'h7FFE);
        rd(3'd5, v); check("R1 level reg", v, 16'h0000);

        // Reserved trigger bits and full field storage
        wr(3'd1, 16'hFFFF); rd(3'd1, v); check("R2 trig_lo reserved", v, 16'hFFFC);
        wr(3'd0, 16'hA5C3); rd(3'd0, v); check("R2 trig_hi store", v, 16'hA5C3);
        wr(3'd0, 16'h0000); wr(3'd1, 16'h0000);
        clear_all();

        // Sweep every source under every trigger code
        for (int n = 1; n <= NSRC; n++) begin
            for (int m = 0; m < 4; m++) begin
                logic        idle_v;
                logic [15:0] bit_n;
                idle_v = (m == 1 || m == 3);
                bit_n  = 16'd1 << n;
                set_mode(n, m);
                wr(3'd4, 16'hFFFF & ~bit_n);
                irq_in[n] = idle_v;
                idle(5);
                clear_all();
                rd(3'd2, v); check($sformatf("R4 idle no trigger src%0d code%0d", n, m), v, 16'h0000);
                check($sformatf("R8 idle level src%0d code%0d", n, m), 16'(irq_level), 16'h0000);
                if (m < 2) begin
                    irq_in[n] = ~idle_v;
                    idle(5);
                    rd(3'd2, v); check($sformatf("R3 asserted src%0d code%0d", n, m), v, bit_n);
                    check($sformatf("R8 level src%0d code%0d", n, m), 16'(irq_level), 16'(n));
                    wr(3'd3, bit_n);
                    rd(3'd2, v); check($sformatf("R6 clear while asserted src%0d", n), v, bit_n);
                    irq_in[n] = idle_v;
                    idle(5);
                    rd(3'd2, v); check($sformatf("R3 latched src%0d code%0d", n, m), v, bit_n);
                    wr(3'd3, bit_n);
                    rd(3'd2, v); check($sformatf("R6 clear src%0d", n), v, 16'h0000);
                end else begin
                    irq_in[n] = ~idle_v;
                    idle(2);
                    irq_in[n] = idle_v;
                    idle(5);
                    rd(3'd2, v); check($sformatf("R4 edge src%0d code%0d", n, m), v, bit_n);
                    check($sformatf("R8 level src%0d code%0d", n, m), 16'(irq_level), 16'(n));
                    wr(3'd3, bit_n);
                    rd(3'd2, v); check($sformatf("R6 clear edge src%0d", n), v, 16'h0000);
                end
                wr(3'd5, 16'h0010);
                idle(2);
                check($sformatf("R10 rearb empty src%0d code%0d", n, m), 16'(irq_level), 16'h0000);
                irq_in[n] = 1'b0;
                idle(4);
                set_mode(n, 0);
                wr(3'd4, 16'hFFFE);
                clear_all();
            end
        end

        // Priority, hold and re-arbitration (all high-level mode)
        wr(3'd4, 16'h0000);
        clear_all();
        irq_in[3] = 1'b1; irq_in[9] = 1'b1;
        idle(5);
        check("R8 highest of 3,9", 16'(irq_level), 16'd9);
        irq_in[12] = 1'b1;
        idle(5);
        check("R9 hold under higher", 16'(irq_level), 16'd9);
        rd(3'd2, v); check("R5 sense 3,9,12", v, 16'h1208);
        wr(3'd5, 16'h0010);
        check("R10 zero after command", 16'(irq_level), 16'h0000);
        idle(1);
        check("R10 rearb to 12", 16'(irq_level), 16'd12);
        irq_in[12] = 1'b0;
        idle(4);
        wr(3'd3, 16'h1000);
        idle(2);
        check("R9 hold after own clear", 16'(irq_level), 16'd12);
        wr(3'd5, 16'h000C);
        idle(2);
        check("R10 no bit4 no effect", 16'(irq_level), 16'd12);
        wr(3'd5, 16'h0010);
        idle(1);
        check("R10 rearb to 9", 16'(irq_level), 16'd9);
        rd(3'd5, v); check("R10 level reg read", v, 16'h0009);
        irq_in[9] = 1'b0;
        idle(4);
        wr(3'd3, 16'h0200);
        wr(3'd5, 16'h0010);
        idle(1);
        check("R8 rearb to 3", 16'(irq_level), 16'd3);
        irq_in[3] = 1'b0;
        idle(4);
        wr(3'd3, 16'h0008);
        wr(3'd5, 16'h0010);
        idle(1);
        check("R8 none left", 16'(irq_level), 16'h0000);

        // Mask and non-maskable source
        wr(3'd4, 16'hFFFF);
        rd(3'd4, v); check("R7 mask reserved bits", v, 16'h7FFE);
        irq_in[5] = 1'b1;
        idle(5);
        rd(3'd2, v); check("R5 sense ignores mask", v, 16'h0020);
        check("R7 masked no level", 16'(irq_level), 16'h0000);
        irq_in[15] = 1'b1;
        for (int k = 0; k < 10; k++) begin
            rd(3'd2, v);
            if (v[15]) break;
            @(negedge clk);
        end
        check("R8 level one clock after pending", 16'(irq_level), 16'h0000);
        idle(1);
        check("R7 source 15 unmaskable", 16'(irq_level), 16'd15);
        wr(3'd3, 16'h0000);
        rd(3'd2, v); check("R6 zero write no effect", v, 16'h8020);
        wr(3'd2, 16'h0000);
        rd(3'd2, v); check("R5 sense write ignored", v, 16'h8020);
        rd(3'd3, v); check("R6 clear reads zero", v, 16'h0000);
        irq_in = '0;
        idle(4);
        clear_all();
        check("R8 final empty", 16'(irq_level), 16'h0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule